// File: doc/BRIEF.md
# Protection Downgrade Erase Sequencer

This block runs the memory wipe that must happen when read protection is lowered from level 1 to level 0 on a two-bank flash. A single start pulse launches the sequence. The block captures the erase policy and the per-bank code-protection settings at that moment. It then issues erase commands one at a time on a command port and waits for the done handshake after each one. The flash array timing sits behind that handshake.

If the full-erase policy bit is set, one mass erase clears both banks. If the bit is clear, each bank with code protection active is erased page by page, and the pages inside that bank's protected window are passed over so the protected code stays. A bank without code protection gets one bank-wide erase. After all bank erasing, the block requests the wipe of the backup registers and the secondary SRAM. Last, it commands the option restore, which brings back the previous user options, including the protection window bounds, with code protection disabled. The one-time-programmable area is never addressed.

Top module: `rdp_erase_seq`

## Requirements
- R1: A high `start_i` sampled while idle raises `busy_o` on the next cycle. A `start_i` sampled while busy has no effect on the command stream.
- R2: With `full_erase_i` set at start, the bank phase is exactly one command with op 2 (mass erase), bank 0, page 0.
- R3: With `full_erase_i` clear, a bank whose `prot_en_i` bit is set gets op 0 (page erase) commands for pages 0 to 2^PAGE_W-1 in ascending order. Pages p with lo <= p <= hi are skipped. The bounds lo and hi are that bank's PAGE_W-bit slice of `prot_lo_i`/`prot_hi_i`, bank b at bits [b*PAGE_W +: PAGE_W]. When lo > hi, the window is empty and every page is erased.
- R4: With `full_erase_i` clear, a bank whose `prot_en_i` bit is clear gets exactly one op 1 (bank erase) command carrying that bank number, page 0.
- R5: Banks are handled in ascending order. Every command for bank b precedes every command for bank b+1, including when both banks are protected.
- R6: After the bank phase, exactly one op 3 command (backup registers and secondary SRAM) follows, and then exactly one op 4 command (restore options, protection window included, with code protection off). Both carry bank 0 and page 0. No other op value is ever issued.
- R7: Only one command is outstanding. `cmd_valid_o` and its op, bank and page stay stable until `cmd_done_i` is sampled high with it. A `cmd_done_i` while `cmd_valid_o` is low is ignored.
- R8: `busy_o` stays high from the cycle after start until the op 4 handshake. In the next cycle `busy_o` is low and `done_o` is high for exactly one cycle.
- R9: Policy, enable and window inputs are captured at start. Changing them while busy has no effect.
- R10: During and right after reset, `busy_o`, `done_o` and `cmd_valid_o` are low.
- R11: A protected window that covers a whole bank produces no commands for that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Downgrade request pulse |
| full_erase_i | input | 1 | 1: one mass erase; 0: per-bank erase honouring code protection |
| prot_en_i | input | N_BANKS | Code protection active, one bit per bank |
| prot_lo_i | input | N_BANKS*PAGE_W | First protected page of each bank |
| prot_hi_i | input | N_BANKS*PAGE_W | Last protected page of each bank (inclusive) |
| cmd_valid_o | output | 1 | Command outstanding |
| cmd_op_o | output | 3 | 0 page, 1 bank, 2 mass, 3 backup+SRAM, 4 option restore |
| cmd_bank_o | output | BANK_W | Target bank for ops 0 and 1, else 0 |
| cmd_page_o | output | PAGE_W | Target page for op 0, else 0 |
| cmd_done_i | input | 1 | Completion of the outstanding command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the restore completes |

## Verification
The sequence is driven with the full-erase policy set, with no bank protected, with one protected bank beside an unprotected one, and with both banks protected. The windows are placed mid-bank, at page 0, at the last page, as single pages, over a whole bank, and reversed so the window is empty. These patterns separate the mass-erase path from the bank-wide and page-walk paths. They expose off-by-one errors at both window edges and at the bank end. They also show whether a fully covered bank is skipped silently and whether bank order holds. In one run the configuration is changed and start is pulsed again mid-sequence, and the command port sees completion strobes and varying latencies while idle.

// File: rtl/rdp_erase_pkg.sv
package rdp_erase_pkg;

  typedef enum logic [2:0] {
    OP_PAGE    = 3'd0,
    OP_BANK    = 3'd1,
    OP_MASS    = 3'd2,
    OP_AUX     = 3'd3,
    OP_RESTORE = 3'd4
  } erase_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ENTER,
    ST_PAGE,
    ST_BANK,
    ST_MASS,
    ST_AUX,
    ST_RESTORE
  } seq_state_e;

endpackage

// File: rtl/rdp_skip_calc.sv
// Moves a candidate page past the protected window; ovf_o marks end of bank.
module rdp_skip_calc #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PAGE_W:0]   cand_i,
  input  logic [PAGE_W-1:0] lo_i,
  input  logic [PAGE_W-1:0] hi_i,
  output logic [PAGE_W-1:0] next_o,
  output logic              ovf_o
);

  logic [PAGE_W:0] lo_x, hi_x, res;
  logic            in_win;

  assign lo_x = {1'b0, lo_i};
  assign hi_x = {1'b0, hi_i};

  always_comb begin
    in_win = (lo_x <= hi_x) && (cand_i >= lo_x) && (cand_i <= hi_x);
    res    = in_win ? hi_x + 1'b1 : cand_i;
  end

  assign next_o = res[PAGE_W-1:0];
  assign ovf_o  = res[PAGE_W];

endmodule

// File: rtl/rdp_cfg_snap.sv
module rdp_cfg_snap #(
  parameter int unsigned N_BANKS = 2,
  parameter int unsigned PAGE_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic                      full_i,
  input  logic [N_BANKS-1:0]        en_i,
  input  logic [N_BANKS*PAGE_W-1:0] lo_i,
  input  logic [N_BANKS*PAGE_W-1:0] hi_i,
  output logic                      full_o,
  output logic [N_BANKS-1:0]        en_o,
  output logic [N_BANKS*PAGE_W-1:0] lo_o,
  output logic [N_BANKS*PAGE_W-1:0] hi_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      en_o   <= '0;
      lo_o   <= '0;
      hi_o   <= '0;
    end else if (load_i) begin
      full_o <= full_i;
      en_o   <= en_i;
      lo_o   <= lo_i;
      hi_o   <= hi_i;
    end
  end

endmodule

// File: rtl/rdp_erase_seq.sv
module rdp_erase_seq
  import rdp_erase_pkg::*;
#(
  parameter int unsigned N_BANKS = 2,
  parameter int unsigned PAGE_W  = 8,
  localparam int unsigned BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      full_erase_i,
  input  logic [N_BANKS-1:0]        prot_en_i,
  input  logic [N_BANKS*PAGE_W-1:0] prot_lo_i,
  input  logic [N_BANKS*PAGE_W-1:0] prot_hi_i,
  output logic                      cmd_valid_o,
  output logic [2:0]                cmd_op_o,
  output logic [BANK_W-1:0]         cmd_bank_o,
  output logic [PAGE_W-1:0]         cmd_page_o,
  input  logic                      cmd_done_i,
  output logic                      busy_o,
  output logic                      done_o
);

  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(N_BANKS - 1);

  seq_state_e          state_q, state_d;
  logic [BANK_W-1:0]   bank_q, bank_d;
  logic [PAGE_W-1:0]   page_q, page_d;
  logic                done_q, done_d;
  logic                adv;

  logic                      full_q;
  logic [N_BANKS-1:0]        en_q;
  logic [N_BANKS*PAGE_W-1:0] lo_q, hi_q;

  rdp_cfg_snap #(
    .N_BANKS (N_BANKS),
    .PAGE_W  (PAGE_W)
  ) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i && (state_q == ST_IDLE)),
    .full_i (full_erase_i),
    .en_i   (prot_en_i),
    .lo_i   (prot_lo_i),
    .hi_i   (prot_hi_i),
    .full_o (full_q),
    .en_o   (en_q),
    .lo_o   (lo_q),
    .hi_o   (hi_q)
  );

  // On entry the walk starts at page 0, afterwards at the page after the last one.
  logic [PAGE_W:0]   cand;
  logic [PAGE_W-1:0] nxt_pg  [N_BANKS];
  logic              nxt_ovf [N_BANKS];
  logic [PAGE_W-1:0] sel_pg;
  logic              sel_ovf;

  assign cand = (state_q == ST_ENTER) ? '0 : {1'b0, page_q} + 1'b1;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    rdp_skip_calc #(
      .PAGE_W (PAGE_W)
    ) u_skip (
      .cand_i (cand),
      .lo_i   (lo_q[b*PAGE_W +: PAGE_W]),
      .hi_i   (hi_q[b*PAGE_W +: PAGE_W]),
      .next_o (nxt_pg[b]),
      .ovf_o  (nxt_ovf[b])
    );
  end

  assign sel_pg  = nxt_pg[bank_q];
  assign sel_ovf = nxt_ovf[bank_q];

  always_comb begin
    state_d = state_q;
    bank_d  = bank_q;
    page_d  = page_q;
    done_d  = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ENTER;
          bank_d  = '0;
        end
      end
      ST_ENTER: begin
        if (full_q)              state_d = ST_MASS;
        else if (!en_q[bank_q])  state_d = ST_BANK;
        else if (sel_ovf)        adv     = 1'b1;
        else begin
          page_d  = sel_pg;
          state_d = ST_PAGE;
        end
      end
      ST_PAGE: begin
        if (cmd_done_i) begin
          if (sel_ovf) adv    = 1'b1;
          else         page_d = sel_pg;
        end
      end
      ST_BANK:    if (cmd_done_i) adv = 1'b1;
      ST_MASS:    if (cmd_done_i) state_d = ST_AUX;
      ST_AUX:     if (cmd_done_i) state_d = ST_RESTORE;
      ST_RESTORE: begin
        if (cmd_done_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (adv) begin
      if (bank_q == LAST_BANK) state_d = ST_AUX;
      else begin
        bank_d  = bank_q + 1'b1;
        state_d = ST_ENTER;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bank_q  <= '0;
      page_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bank_q  <= bank_d;
      page_q  <= page_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    cmd_valid_o = 1'b1;
    cmd_op_o    = OP_PAGE;
    cmd_bank_o  = '0;
    cmd_page_o  = '0;
    unique case (state_q)
      ST_PAGE: begin
        cmd_bank_o = bank_q;
        cmd_page_o = page_q;
      end
      ST_BANK: begin
        cmd_op_o   = OP_BANK;
        cmd_bank_o = bank_q;
      end
      ST_MASS:    cmd_op_o = OP_MASS;
      ST_AUX:     cmd_op_o = OP_AUX;
      ST_RESTORE: cmd_op_o = OP_RESTORE;
      default:    cmd_valid_o = 1'b0;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/rdp_erase_seq_chk.sv
module rdp_erase_seq_chk
  import rdp_erase_pkg::*;
#(
  parameter int unsigned N_BANKS = 2,
  parameter int unsigned PAGE_W  = 8,
  localparam int unsigned BANK_W = (N_BANKS > 1) ? $clog2(N_BANKS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              cmd_valid_o,
  input logic [2:0]        cmd_op_o,
  input logic [BANK_W-1:0] cmd_bank_o,
  input logic [PAGE_W-1:0] cmd_page_o,
  input logic              cmd_done_i,
  input logic              busy_o,
  input logic              done_o
);

  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);

  p_hold_cmd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_done_i |=> cmd_valid_o && $stable(cmd_op_o)
      && $stable(cmd_bank_o) && $stable(cmd_page_o));

  p_aux_then_restore_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_done_i && (cmd_op_o == OP_AUX) |=>
      cmd_valid_o && (cmd_op_o == OP_RESTORE));

  p_op_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_op_o <= OP_RESTORE);

  p_valid_in_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

endmodule

bind rdp_erase_seq rdp_erase_seq_chk #(
  .N_BANKS (N_BANKS),
  .PAGE_W  (PAGE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .cmd_bank_o  (cmd_bank_o),
  .cmd_page_o  (cmd_page_o),
  .cmd_done_i  (cmd_done_i),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/rdp_erase_seq_tb.sv
module rdp_erase_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 2;
  localparam int PW         = 8;
  localparam int NP         = 1 << PW;
  localparam int LIMIT      = 150000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          full;
  logic [NB-1:0] en;
  logic [NB*PW-1:0] lo, hi;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [0:0]    cmd_bank;
  logic [PW-1:0] cmd_page;
  logic          cmd_done;
  logic          busy, done;

  int compared = 0;
  int mism     = 0;
  int cyc      = 0;
  int wait_cnt = -1;
  bit stray    = 1'b0;

  int q_op[$], q_bank[$], q_page[$];
  bit m_busy = 1'b0;
  bit m_done = 1'b0;

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  rdp_erase_seq #(.N_BANKS(NB), .PAGE_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .full_erase_i(full),
    .prot_en_i(en), .prot_lo_i(lo), .prot_hi_i(hi),
    .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .cmd_bank_o(cmd_bank),
    .cmd_page_o(cmd_page), .cmd_done_i(cmd_done), .busy_o(busy), .done_o(done)
  );

  task automatic check_eq(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mism++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic void push(int op, int bank, int page);
    q_op.push_back(op); q_bank.push_back(bank); q_page.push_back(page);
  endfunction

  function automatic void build_exp();
    if (full) push(2, 0, 0);
    else begin
      for (int b = 0; b < NB; b++) begin
        int l = int'(lo[b*PW +: PW]);
        int h = int'(hi[b*PW +: PW]);
        if (!en[b]) push(1, b, 0);
        else for (int p = 0; p < NP; p++)
          if (!(l <= h && p >= l && p <= h)) push(0, b, p);
      end
    end
    push(3, 0, 0);
    push(4, 0, 0);
  endfunction

  function automatic string req_of(int op);
    case (op)
      0: return "R3 R5 R11 page";
      1: return "R4 R5 bank";
      2: return "R2 mass";
      default: return "R6 aux/restore";
    endcase
  endfunction

  // Reference model: compare at negedge, then predict the next edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      check_eq("R10 reset busy", int'(busy), 0);
      check_eq("R10 reset done", int'(done), 0);
      check_eq("R10 reset valid", int'(cmd_valid), 0);
    end else begin
      check_eq("R8 busy", int'(busy), int'(m_busy));
      check_eq("R8 done", int'(done), int'(m_done));
      if (cmd_valid) begin
        if (q_op.size() == 0) check_eq("R6 no extra command", 1, 0);
        else begin
          check_eq({req_of(q_op[0]), " op"}, int'(cmd_op), q_op[0]);
          check_eq({req_of(q_op[0]), " bank"}, int'(cmd_bank), q_bank[0]);
          check_eq({req_of(q_op[0]), " page"}, int'(cmd_page), q_page[0]);
        end
      end
      m_done = 1'b0;
      if (!m_busy && start) begin
        m_busy = 1'b1;
        build_exp();
      end else if (cmd_valid && cmd_done && q_op.size() > 0) begin
        void'(q_op.pop_front()); void'(q_bank.pop_front()); void'(q_page.pop_front());
        if (q_op.size() == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
        end
      end
    end
  end

  // Command responder with varying latency and stray strobes while idle (R7).
  always begin
    @(posedge clk); #1;
    if (!rst_n) begin
      cmd_done = 1'b0;
      wait_cnt = -1;
    end else if (cmd_done) cmd_done = 1'b0;
    else if (cmd_valid) begin
      if (wait_cnt < 0) wait_cnt = cyc % 3;
      if (wait_cnt == 0) begin
        cmd_done = 1'b1;
        wait_cnt = -1;
      end else wait_cnt--;
    end else cmd_done = stray && (cyc % 5 == 2);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT) begin
      compared++;
      mism++;
      $display("FAIL watchdog actual %0d expected < %0d", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
      $finish;
    end
  end

  task automatic run_case(bit f, logic [1:0] e, int l0, int h0, int l1, int h1, bit disturb);
    @(posedge clk); #1;
    full = f;
    en   = e;
    lo   = {PW'(l1), PW'(l0)};
    hi   = {PW'(h1), PW'(h0)};
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (disturb) begin
      repeat (5) @(posedge clk);
      #1;
      start = 1'b1;  // R1: ignored while busy
      full  = ~f;    // R9: ignored while busy
      en    = ~e;
      lo    = ~lo;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (m_busy) @(posedge clk);
    repeat (3) @(posedge clk);
    check_eq("R8 queue drained", q_op.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; full = 1'b0; en = '0; lo = '0; hi = '0; cmd_done = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    stray = 1'b1;
    run_case(1'b1, 2'b11, 3, 9, 0, 4, 1'b0);          // R2 mass
    run_case(1'b0, 2'b00, 0, 0, 0, 0, 1'b0);          // R4 both bank-wide
    run_case(1'b0, 2'b01, 10, 20, 0, 0, 1'b1);        // R3 R4 R9 R1
    run_case(1'b0, 2'b11, 100, 150, 0, 5, 1'b0);      // R5 both paged, window at 0
    run_case(1'b0, 2'b11, 0, NP-1, 200, 100, 1'b0);   // R11 full cover, empty window
    run_case(1'b0, 2'b11, NP-1, NP-1, 0, 0, 1'b0);    // single page edges
    run_case(1'b0, 2'b10, 5, 5, 250, NP-1, 1'b0);     // R4 then R3 window to end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mism);
    $finish;
  end

endmodule